// File: doc/BRIEF.md
# Receiver Word Latch with Two-Half Readout

This block sits behind a serial word receiver. When the receiver reports that a 32-bit word is complete, the block may capture that word into a holding register. An optional filter on two label bits decides whether the capture happens. After a capture, an active-low ready flag tells the host that a word is waiting. The host reads the word as two 16-bit halves through a shared output. It uses a read strobe together with a half-select line.

The ready flag stays low until the host has read both halves. The two halves may be read in either order. A half read twice counts once. An accepted word that arrives before the host finishes replaces the held word and restarts the read progress. A dual-receiver interface uses one instance per receiver, and each instance has its own read strobe.

Word bit numbering: serial bit n (1..32) is `wordIn[n-1]`. The filter therefore looks at `wordIn[8]` (serial bit 9) and `wordIn[9]` (serial bit 10).

Top module: `rx_word_latch`

## Requirements
- R1: After reset, `readyN` is 1 and `dataOut` is 0.
- R2: With `filterOn` = 0, a cycle with `eosPulse` = 1 latches `wordIn`, and `readyN` is 0 after that clock edge.
- R3: With `filterOn` = 1, a word is latched only when `wordIn[8]` equals `matchBits[0]` and `wordIn[9]` equals `matchBits[1]`. A rejected word leaves the held word and `readyN` unchanged.
- R4: While `rdEn` = 1, `dataOut` shows held bits [15:0] when `halfSel` = 0 and bits [31:16] when `halfSel` = 1. While `rdEn` = 0, `dataOut` is 0.
- R5: `readyN` stays 0 until both halves have been read. Reading the same half repeatedly does not release it.
- R6: `readyN` returns to 1 at the first clock edge that samples `rdEn` = 0 after the strobe that completes the second half. The halves may be read in either order.
- R7: An accepted word that arrives while `readyN` = 0 overwrites the held word and clears read progress, and `readyN` stays 0.
- R8: The half credited by a strobe is the `halfSel` value at the last clock edge where `rdEn` was 1.
- R9: When an accepted word arrives in the same cycle as the trailing edge that would complete a readout, the new word wins. `readyN` stays 0 and read progress is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eosPulse | input | 1 | One-cycle pulse: receiver finished a word |
| wordIn | input | 32 | Assembled word, valid while eosPulse is 1 |
| filterOn | input | 1 | 1 enables the bit 9/10 filter |
| matchBits | input | 2 | Required values of serial bits 9 ([0]) and 10 ([1]) |
| rdEn | input | 1 | Host read strobe, active high |
| halfSel | input | 1 | 0 selects bits [15:0], 1 selects bits [31:16] |
| dataOut | output | 16 | Selected half while rdEn is 1, else 0 |
| readyN | output | 1 | Active-low word-ready flag |

## Verification
The assertions assume that `eosPulse` is high for single cycles only, and that `wordIn` is valid in those cycles. They also assume that `rdEn` and `halfSel` change only between clock edges. The bench drives every input on the falling clock edge and keeps each end-of-word pulse to one cycle. Each read strobe is followed by at least one low cycle, so every trailing edge is seen by a rising edge. Collisions between an end-of-word pulse and a trailing edge are created on purpose, and only in the R9 scenario.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int WORD_W_DEF = 32;
  localparam int FLT_W_DEF  = 2;
  localparam int FLT_POS_DEF = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic holdWord;
  } ctlStrobe_t;
endpackage

// File: rtl/rxw_match.sv
module rxw_match #(
  parameter int WORD_W  = 32,
  parameter int FLT_W   = 2,
  parameter int FLT_POS = 8
) (
  input  logic [WORD_W-1:0] wordIn,
  input  logic [FLT_W-1:0]  matchBits,
  input  logic              filterOn,
  output logic              wordPass
);
  logic [FLT_W-1:0] bitEq;

  // One comparator per filtered bit
  for (genvar i = 0; i < FLT_W; i++) begin : g_cmp
    assign bitEq[i] = (wordIn[FLT_POS+i] == matchBits[i]);
  end

  always_comb begin
    if (!filterOn) wordPass = 1'b1;
    else           wordPass = &bitEq;
  end
endmodule

// File: rtl/rxw_datapath.sv
module rxw_datapath
  import rxw_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              rdEn,
  input  logic              halfSel,
  output logic [HALF_W-1:0] dataOut
);
  logic [WORD_W-1:0] latchQ;
  logic [HALF_W-1:0] halfLo, halfHi;

  always_ff @(posedge clk) begin
    if (!rstN)             latchQ <= '0;
    else if (ctl.loadWord) latchQ <= wordIn;
  end

  assign halfLo = latchQ[HALF_W-1:0];
  assign halfHi = latchQ[WORD_W-1:HALF_W];

  always_comb begin
    if (!rdEn)        dataOut = '0;
    else if (halfSel) dataOut = halfHi;
    else              dataOut = halfLo;
  end

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdWord |=> $stable(latchQ));

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWord |=> (latchQ == $past(wordIn)));
endmodule

// File: rtl/rxw_control.sv
module rxw_control
  import rxw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       eosPulse,
  input  logic       wordPass,
  input  logic       rdEn,
  input  logic       halfSel,
  output ctlStrobe_t ctl,
  output logic       readyN
);
  logic enPrev, selHeld, readLo, readHi;
  logic accept, trail, otherDone;

  assign accept = eosPulse & wordPass;
  assign trail  = enPrev & ~rdEn;
  assign otherDone = selHeld ? readLo : readHi;

  always_comb begin
    ctl.loadWord = accept;
    ctl.holdWord = ~accept;
  end

  // Strobe tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      selHeld <= 1'b0;
    end else begin
      enPrev <= rdEn;
      if (rdEn) selHeld <= halfSel;
    end
  end

  // Read progress and ready flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyN <= 1'b1;
      readLo <= 1'b0;
      readHi <= 1'b0;
    end else if (accept) begin
      readyN <= 1'b0;
      readLo <= 1'b0;
      readHi <= 1'b0;
    end else if (trail && !readyN) begin
      if (otherDone) begin
        readyN <= 1'b1;
        readLo <= 1'b0;
        readHi <= 1'b0;
      end else if (selHeld) begin
        readHi <= 1'b1;
      end else begin
        readLo <= 1'b1;
      end
    end
  end

  // R2
  ready_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWord |=> !readyN);

  // R7
  progress_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWord |=> (!readLo && !readHi));

  // R6
  release_on_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyN) |-> $past(trail));

  // R5
  no_early_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyN && !trail && !accept) |=> !readyN);
endmodule

// File: rtl/rx_word_latch.sv
module rx_word_latch
  import rxw_pkg::*;
#(
  parameter int WORD_W  = WORD_W_DEF,
  parameter int FLT_W   = FLT_W_DEF,
  parameter int FLT_POS = FLT_POS_DEF,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eosPulse,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              filterOn,
  input  logic [FLT_W-1:0]  matchBits,
  input  logic              rdEn,
  input  logic              halfSel,
  output logic [HALF_W-1:0] dataOut,
  output logic              readyN
);
  ctlStrobe_t ctl;
  logic wordPass;

  rxw_match #(.WORD_W(WORD_W), .FLT_W(FLT_W), .FLT_POS(FLT_POS)) u_match (
    .wordIn(wordIn), .matchBits(matchBits), .filterOn(filterOn),
    .wordPass(wordPass));

  rxw_control u_ctl (
    .clk(clk), .rstN(rstN), .eosPulse(eosPulse), .wordPass(wordPass),
    .rdEn(rdEn), .halfSel(halfSel), .ctl(ctl), .readyN(readyN));

  rxw_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIn(wordIn),
    .rdEn(rdEn), .halfSel(halfSel), .dataOut(dataOut));
endmodule

// File: tb/sim_rx_word_latch.sv
module sim_rx_word_latch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eosPulse = 1'b0;
  logic [31:0] wordIn = '0;
  logic filterOn = 1'b0;
  logic [1:0] matchBits = '0;
  logic rdEn = 1'b0;
  logic halfSel = 1'b0;
  logic [15:0] dataOut;
  logic readyN;
  int nChk = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  rx_word_latch u0 (.clk(clk), .rstN(rstN), .eosPulse(eosPulse), .wordIn(wordIn),
    .filterOn(filterOn), .matchBits(matchBits), .rdEn(rdEn), .halfSel(halfSel),
    .dataOut(dataOut), .readyN(readyN));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk); eosPulse = 1'b1; wordIn = w;
    @(negedge clk); eosPulse = 1'b0; wordIn = '0;
  endtask

  // One-cycle strobe, checks data, then one low cycle so the trailing edge lands
  task automatic readHalf(input logic sel, input logic [15:0] exp, input string req);
    @(negedge clk); rdEn = 1'b1; halfSel = sel;
    #1 chk(req, 32'(dataOut), 32'(exp));
    @(negedge clk); rdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset;
    chk("R1 readyN", 32'(readyN), 1);
    chk("R1 dataOut", 32'(dataOut), 0);
  endtask

  task automatic testBasic;
    sendWord(32'hA5A5_1234);
    chk("R2 readyN low", 32'(readyN), 0);
    chk("R4 idle out zero", 32'(dataOut), 0);
    readHalf(1'b0, 16'h1234, "R4 low half");
    chk("R5 after one half", 32'(readyN), 0);
    readHalf(1'b0, 16'h1234, "R5 same half again");
    chk("R5 repeat no release", 32'(readyN), 0);
    readHalf(1'b1, 16'hA5A5, "R4 high half");
    chk("R6 released", 32'(readyN), 1);
  endtask

  task automatic testOrderAndTiming;
    sendWord(32'h0F0F_F0F0);
    readHalf(1'b1, 16'h0F0F, "R6 high first");
    chk("R6 one half", 32'(readyN), 0);
    @(negedge clk); rdEn = 1'b1; halfSel = 1'b0;
    @(negedge clk); rdEn = 1'b0;
    #1 chk("R6 not before trailing edge seen", 32'(readyN), 0);
    @(negedge clk);
    chk("R6 release after trailing edge", 32'(readyN), 1);
  endtask

  task automatic testFilter;
    filterOn = 1'b1; matchBits = 2'b10;   // bit9=0, bit10=1
    sendWord(32'h1111_0200);               // [9]=1,[8]=0 -> match
    chk("R3 match accepted", 32'(readyN), 0);
    readHalf(1'b0, 16'h0200, "R3 match low");
    readHalf(1'b1, 16'h1111, "R3 match high");
    chk("R3 released", 32'(readyN), 1);
    sendWord(32'h2222_0100);               // [9]=0,[8]=1 -> reject
    chk("R3 reject keeps readyN", 32'(readyN), 1);
    readHalf(1'b1, 16'h1111, "R3 reject keeps word");
    sendWord(32'h3333_0200);               // accept
    sendWord(32'h4444_0300);               // [9]=1,[8]=1 -> reject while pending
    chk("R3 reject while pending", 32'(readyN), 0);
    readHalf(1'b1, 16'h3333, "R3 pending word kept");
    readHalf(1'b0, 16'h0200, "R3 pending low");
    chk("R3 done", 32'(readyN), 1);
    filterOn = 1'b0;
    sendWord(32'h5555_0300);
    chk("R2 filter off accepts", 32'(readyN), 0);
    readHalf(1'b0, 16'h0300, "R2 low");
    readHalf(1'b1, 16'h5555, "R2 high");
  endtask

  task automatic testOverwrite;
    sendWord(32'hAAAA_BBBB);
    readHalf(1'b0, 16'hBBBB, "R7 first low");
    sendWord(32'hCCCC_DDDD);
    chk("R7 still pending", 32'(readyN), 0);
    readHalf(1'b1, 16'hCCCC, "R7 new high");
    chk("R7 progress cleared", 32'(readyN), 0);
    readHalf(1'b0, 16'hDDDD, "R7 new low");
    chk("R7 release", 32'(readyN), 1);
  endtask

  task automatic testSelSample;
    sendWord(32'h1357_2468);
    @(negedge clk); rdEn = 1'b1; halfSel = 1'b0;
    @(negedge clk); halfSel = 1'b1;
    #1 chk("R8 out follows sel", 32'(dataOut), 32'h1357);
    @(negedge clk); rdEn = 1'b0; halfSel = 1'b0;
    @(negedge clk);
    readHalf(1'b1, 16'h1357, "R8 high again");
    chk("R8 high credited only", 32'(readyN), 0);
    readHalf(1'b0, 16'h2468, "R8 low");
    chk("R8 release", 32'(readyN), 1);
  endtask

  task automatic testCollision;
    sendWord(32'h9999_8888);
    readHalf(1'b0, 16'h8888, "R9 low");
    @(negedge clk); rdEn = 1'b1; halfSel = 1'b1;
    @(negedge clk); rdEn = 1'b0; eosPulse = 1'b1; wordIn = 32'h7777_6666;
    @(negedge clk); eosPulse = 1'b0; wordIn = '0;
    chk("R9 new word wins", 32'(readyN), 0);
    readHalf(1'b1, 16'h7777, "R9 new high");
    chk("R9 progress cleared", 32'(readyN), 0);
    readHalf(1'b0, 16'h6666, "R9 new low");
    chk("R9 release", 32'(readyN), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testOrderAndTiming();
    testFilter();
    testOverwrite();
    testSelSample();
    testCollision();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    #100000;
    nErr++; nChk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule